// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Channel Test Modes

This block is a two-wire asynchronous serial port. A transmitter and a receiver work independently of each other. Both take their timing from one programmable baud generator, which divides the system clock by 16 × CD. Each character is a low start bit, 8 data bits sent least significant bit first, an optional parity bit and one high stop bit. The parity can be even, odd, forced-1 (mark) or forced-0 (space). The receiver takes 16 samples per bit. It checks the start bit again at mid-bit, and it decides each later bit by a majority vote of three samples that end at the bit centre. It records parity, framing and overrun errors in sticky flags.

A host reaches the block through a small register port. A write is `wr_en` plus `addr`. A read is `rd_en` plus `addr`, and `rd_data` is registered one clock after the read. The registers are: configuration at address 0, divider at 1, transmit data at 2, receive data at 3, status at 4 and command at 5. The transmit side has one holding register and the receive side has one buffer register. Two level request lines, `tx_dreq` and `rx_dreq`, let one DMA channel serve each direction. A channel-mode field sets the routing. In normal mode the transmitter drives the TX pin and the receiver listens to the RX pin. Automatic echo, local loopback and remote loopback change this routing for testing.

Both engines are state machines with the states FR_IDLE, FR_START, FR_DATA, FR_PARITY and FR_STOP.
- Transmitter transitions:
  - FR_IDLE to FR_START on a baud tick while the holding register is full.
  - FR_START to FR_DATA after 16 ticks.
  - FR_DATA to FR_PARITY, or to FR_STOP when there is no parity, after the eighth data bit.
  - FR_PARITY to FR_STOP after 16 ticks.
  - FR_STOP to FR_IDLE after 16 ticks.
- Receiver transitions:
  - FR_IDLE to FR_START on a tick that sees the line low.
  - FR_START back to FR_IDLE if the line is high again at the mid-bit check (a false start). FR_START to FR_DATA if the line is still low.
  - FR_DATA, FR_PARITY and FR_STOP advance on every 16th tick, in the same order as the transmitter.
  - FR_STOP to FR_IDLE at the centre of the stop bit, where the character is delivered.

Top module: `sp_uart`

## Requirements
- R1: The divider register (address 1) holds CD. Every serial bit lasts exactly 16 × CD clocks. A CD of 0 stops the baud generator, so a byte waiting in the holding register is not sent and the TX pin stays high.
- R2: In normal mode (configuration bits [5:4] = 0), writing transmit data (address 2) sends a frame on `txd_pin`: a low start bit, then data bits 0 to 7 in that order, then the parity bit if parity is on, then a high stop bit. The line is high when idle.
- R3: Configuration bits [2:0] select parity: 0 even, 1 odd, 2 space (bit always 0), 3 mark (bit always 1), 4 to 7 no parity bit. Frames that match the selected parity are received with no error flag.
- R4: When a frame completes, the receive data register (address 3) holds the byte, and status bit 0 and `rx_dreq` go high. A read of address 3 clears both.
- R5: Status bit 5 (parity error) is set when the received parity bit differs from the one the selected mode calls for.
- R6: Status bit 4 (framing error) is set when the stop bit is sampled low.
- R7: Status bit 3 (overrun) is set when a frame completes while status bit 0 is still high. Address 3 then holds the newer byte.
- R8: The error flags stay set through later error-free frames. Only a write to the command register (address 5) with bit 0 = 1, or a reset, clears them.
- R9: In echo mode (configuration bits [5:4] = 1), `txd_pin` follows `rxd_pin` and the receiver still receives. Transmitter output never reaches the pin.
- R10: In local loopback (configuration bits [5:4] = 2), the transmitter feeds the receiver internally, `txd_pin` stays high, and `rxd_pin` has no effect.
- R11: In remote loopback (configuration bits [5:4] = 3), `txd_pin` follows `rxd_pin` and the receiver sees an idle line, so no byte is received.
- R12: `tx_dreq` and status bit 1 are high while the transmit holding register is empty. Status bit 2 is high when the holding register is empty and the transmitter is idle. After reset the status register reads 0x0006.
- R13: A low pulse on the receive line shorter than half a bit is rejected as a false start. No byte is received, and the next valid frame is received normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW (3) | Register address |
| wr_data | input | DW (16) | Write data |
| rd_data | output | DW (16) | Read data, valid the clock after `rd_en` |
| rxd_pin | input | 1 | Serial receive pin |
| txd_pin | output | 1 | Serial transmit pin |
| rx_dreq | output | 1 | Receive request: a byte is waiting |
| tx_dreq | output | 1 | Transmit request: the holding register is empty |

## Verification
The assertions assume the host never asserts `wr_en` and `rd_en` in the same cycle. They also assume the divider and channel mode change only while both engines are idle, and that the receive line holds each bit for a whole bit period. The bench meets these assumptions as follows:
- Each register access is a single-strobe task.
- Configuration is written only between frames, after the previous frame has been given enough idle time to finish.
- Serial frames are driven with bit periods of exactly 16 × CD clocks, aligned to the falling clock edge.
- Short glitches appear only in the dedicated false-start scenario.

// File: rtl/sp_pkg.sv
package sp_pkg;

    // Register addresses
    localparam int A_CFG  = 0;
    localparam int A_DIV  = 1;
    localparam int A_TXD  = 2;
    localparam int A_RXD  = 3;
    localparam int A_STAT = 4;
    localparam int A_CMD  = 5;

    typedef enum logic [1:0] {
        CH_NORMAL = 2'd0,
        CH_ECHO   = 2'd1,
        CH_LOCAL  = 2'd2,
        CH_REMOTE = 2'd3
    } chmode_e;

    typedef enum logic [2:0] {
        FR_IDLE   = 3'd0,
        FR_START  = 3'd1,
        FR_DATA   = 3'd2,
        FR_PARITY = 3'd3,
        FR_STOP   = 3'd4
    } frame_st_e;

    // Parity bit from the XOR of the data bits and the mode select
    function automatic logic par_from(input logic xr, input logic [2:0] sel);
        logic p;
        unique case (sel[1:0])
            2'd0:    p = xr;
            2'd1:    p = ~xr;
            2'd2:    p = 1'b0;
            default: p = 1'b1;
        endcase
        return p;
    endfunction

    function automatic logic par_on(input logic [2:0] sel);
        return ~sel[2];
    endfunction

endpackage

// File: rtl/sp_baud.sv
module sp_baud #(
    parameter int CDW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [CDW-1:0] cd,
    output logic           tick
);
    logic [CDW-1:0] cnt;

    assign tick = (cd != '0) && (cnt >= cd - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (tick || cd == '0) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sp_tx.sv
module sp_tx import sp_pkg::*; #(
    parameter int DBITS = 8,
    parameter int OSR   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load_req,
    input  logic [DBITS-1:0] load_data,
    input  logic [2:0]       par_sel,
    output logic             load_ack,
    output logic             tx_line,
    output logic             busy
);
    localparam int OW = $clog2(OSR);
    localparam int IW = (DBITS > 1) ? $clog2(DBITS) : 1;

    frame_st_e        st, st_n;
    logic [OW-1:0]    cnt;
    logic [IW-1:0]    idx;
    logic [DBITS-1:0] sh;
    logic             pen, pbit;
    logic             bit_end;

    assign bit_end = tick && (cnt == OW'(OSR - 1));

    // Next state
    always_comb begin
        st_n = st;
        unique case (st)
            FR_IDLE:   if (tick && load_req) st_n = FR_START;
            FR_START:  if (bit_end) st_n = FR_DATA;
            FR_DATA:   if (bit_end && idx == IW'(DBITS - 1)) st_n = pen ? FR_PARITY : FR_STOP;
            FR_PARITY: if (bit_end) st_n = FR_STOP;
            FR_STOP:   if (bit_end) st_n = FR_IDLE;
            default:   st_n = FR_IDLE;
        endcase
    end

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= FR_IDLE;
            cnt  <= '0;
            idx  <= '0;
            sh   <= '0;
            pen  <= 1'b0;
            pbit <= 1'b0;
        end else begin
            st <= st_n;
            if (st == FR_IDLE) begin
                cnt <= '0;
                idx <= '0;
                if (tick && load_req) begin
                    sh   <= load_data;
                    pen  <= par_on(par_sel);
                    pbit <= par_from(^load_data, par_sel);
                end
            end else if (tick) begin
                cnt <= bit_end ? '0 : cnt + 1'b1;
                if (bit_end && st == FR_DATA) begin
                    sh  <= sh >> 1;
                    idx <= (idx == IW'(DBITS - 1)) ? '0 : idx + 1'b1;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        load_ack = (st == FR_IDLE) && tick && load_req;
        busy     = (st != FR_IDLE);
        unique case (st)
            FR_START:  tx_line = 1'b0;
            FR_DATA:   tx_line = sh[0];
            FR_PARITY: tx_line = pbit;
            default:   tx_line = 1'b1;
        endcase
    end
endmodule

// File: rtl/sp_rx.sv
module sp_rx import sp_pkg::*; #(
    parameter int DBITS = 8,
    parameter int OSR   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             rx_in,
    input  logic [2:0]       par_sel,
    output logic             done,
    output logic [DBITS-1:0] data,
    output logic             perr,
    output logic             ferr
);
    localparam int OW = $clog2(OSR);
    localparam int IW = (DBITS > 1) ? $clog2(DBITS) : 1;

    frame_st_e        st, st_n;
    logic [OW-1:0]    cnt;
    logic [IW-1:0]    idx;
    logic [DBITS-1:0] sh;
    logic [1:0]       hist;
    logic             pval;
    logic             bit_end, mid, vote;

    assign bit_end = tick && (cnt == OW'(OSR - 1));
    assign mid     = tick && (cnt == OW'(OSR / 2 - 1));
    assign vote    = (hist[1] & hist[0]) | (hist[1] & rx_in) | (hist[0] & rx_in);

    // Next state
    always_comb begin
        st_n = st;
        unique case (st)
            FR_IDLE:   if (tick && !rx_in) st_n = FR_START;
            FR_START:  if (mid) st_n = rx_in ? FR_IDLE : FR_DATA;
            FR_DATA:   if (bit_end && idx == IW'(DBITS - 1)) st_n = par_on(par_sel) ? FR_PARITY : FR_STOP;
            FR_PARITY: if (bit_end) st_n = FR_STOP;
            FR_STOP:   if (bit_end) st_n = FR_IDLE;
            default:   st_n = FR_IDLE;
        endcase
    end

    // State register and sampling datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= FR_IDLE;
            cnt  <= '0;
            idx  <= '0;
            sh   <= '0;
            hist <= 2'b11;
            pval <= 1'b0;
        end else begin
            st <= st_n;
            if (tick) hist <= {hist[0], rx_in};
            unique case (st)
                FR_IDLE: begin
                    cnt <= '0;
                    idx <= '0;
                end
                FR_START: begin
                    if (tick) cnt <= mid ? '0 : cnt + 1'b1;
                end
                FR_DATA: begin
                    if (tick) cnt <= bit_end ? '0 : cnt + 1'b1;
                    if (bit_end) begin
                        sh  <= {vote, sh[DBITS-1:1]};
                        idx <= (idx == IW'(DBITS - 1)) ? '0 : idx + 1'b1;
                    end
                end
                FR_PARITY: begin
                    if (tick) cnt <= bit_end ? '0 : cnt + 1'b1;
                    if (bit_end) pval <= vote;
                end
                FR_STOP: begin
                    if (tick) cnt <= bit_end ? '0 : cnt + 1'b1;
                end
                default: cnt <= '0;
            endcase
        end
    end

    // Outputs: one delivery per completed frame
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done <= 1'b0;
            data <= '0;
            perr <= 1'b0;
            ferr <= 1'b0;
        end else begin
            done <= 1'b0;
            if (st == FR_STOP && bit_end) begin
                done <= 1'b1;
                data <= sh;
                ferr <= ~vote;
                perr <= par_on(par_sel) && (pval != par_from(^sh, par_sel));
            end
        end
    end
endmodule

// File: rtl/sp_uart.sv
module sp_uart import sp_pkg::*; #(
    parameter int DW    = 16,
    parameter int CDW   = 16,
    parameter int DBITS = 8,
    parameter int OSR   = 16,
    parameter int AW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    input  logic          rxd_pin,
    output logic          txd_pin,
    output logic          rx_dreq,
    output logic          tx_dreq
);
    logic [2:0]       cfg_par;
    chmode_e          mode;
    logic [CDW-1:0]   cd;
    logic [DBITS-1:0] thr, rbr;
    logic             thr_full, rx_ready;
    logic             ovr, fer, per;
    logic             baud_tick;
    logic             tx_ack, tx_line, tx_busy;
    logic             rx_done, rx_perr, rx_ferr;
    logic [DBITS-1:0] rx_data;
    logic             rx_src;
    logic [1:0]       sync;
    logic [DW-1:0]    stat, rd_mux;
    logic             rd_rxd;

    sp_baud #(.CDW(CDW)) u_baud (
        .clk  (clk),
        .rst_n(rst_n),
        .cd   (cd),
        .tick (baud_tick)
    );

    sp_tx #(.DBITS(DBITS), .OSR(OSR)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (baud_tick),
        .load_req (thr_full),
        .load_data(thr),
        .par_sel  (cfg_par),
        .load_ack (tx_ack),
        .tx_line  (tx_line),
        .busy     (tx_busy)
    );

    sp_rx #(.DBITS(DBITS), .OSR(OSR)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (baud_tick),
        .rx_in  (sync[1]),
        .par_sel(cfg_par),
        .done   (rx_done),
        .data   (rx_data),
        .perr   (rx_perr),
        .ferr   (rx_ferr)
    );

    // Channel routing
    always_comb begin
        unique case (mode)
            CH_NORMAL: begin txd_pin = tx_line; rx_src = rxd_pin; end
            CH_ECHO:   begin txd_pin = rxd_pin; rx_src = rxd_pin; end
            CH_LOCAL:  begin txd_pin = 1'b1;    rx_src = tx_line; end
            default:   begin txd_pin = rxd_pin; rx_src = 1'b1;    end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync <= 2'b11;
        else        sync <= {sync[0], rx_src};
    end

    assign rd_rxd  = rd_en && (addr == AW'(A_RXD));
    assign rx_dreq = rx_ready;
    assign tx_dreq = ~thr_full;

    always_comb begin
        stat    = '0;
        stat[0] = rx_ready;
        stat[1] = ~thr_full;
        stat[2] = ~thr_full && ~tx_busy;
        stat[3] = ovr;
        stat[4] = fer;
        stat[5] = per;
        rd_mux  = '0;
        case (addr)
            AW'(A_CFG):  begin rd_mux[2:0] = cfg_par; rd_mux[5:4] = mode; end
            AW'(A_DIV):  rd_mux[CDW-1:0] = cd;
            AW'(A_RXD):  rd_mux[DBITS-1:0] = rbr;
            AW'(A_STAT): rd_mux = stat;
            default:     rd_mux = '0;
        endcase
    end

    // Host registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_par  <= 3'd4;
            mode     <= CH_NORMAL;
            cd       <= '0;
            thr      <= '0;
            thr_full <= 1'b0;
            rbr      <= '0;
            rx_ready <= 1'b0;
            ovr      <= 1'b0;
            fer      <= 1'b0;
            per      <= 1'b0;
            rd_data  <= '0;
        end else begin
            if (tx_ack) thr_full <= 1'b0;
            if (wr_en) begin
                case (addr)
                    AW'(A_CFG): begin
                        cfg_par <= wr_data[2:0];
                        mode    <= chmode_e'(wr_data[5:4]);
                    end
                    AW'(A_DIV): cd <= wr_data[CDW-1:0];
                    AW'(A_TXD): begin
                        thr      <= wr_data[DBITS-1:0];
                        thr_full <= 1'b1;
                    end
                    AW'(A_CMD): if (wr_data[0]) begin
                        ovr <= 1'b0;
                        fer <= 1'b0;
                        per <= 1'b0;
                    end
                    default: ;
                endcase
            end
            if (rd_en) rd_data <= rd_mux;
            if (rd_rxd) rx_ready <= 1'b0;
            if (rx_done) begin
                rbr      <= rx_data;
                rx_ready <= 1'b1;
                if (rx_ready && !rd_rxd) ovr <= 1'b1;
                if (rx_ferr) fer <= 1'b1;
                if (rx_perr) per <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sp_uart_chk.sv
module sp_uart_chk import sp_pkg::*; #(
    parameter int CDW = 16,
    parameter int AW  = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic [1:0]     mode,
    input logic           txd_pin,
    input logic           rxd_pin,
    input logic           rx_dreq,
    input logic           rd_en,
    input logic           wr_en,
    input logic [AW-1:0]  addr,
    input logic           wr_bit0,
    input logic           ovr,
    input logic           fer,
    input logic           per,
    input logic [CDW-1:0] cd,
    input logic           baud_tick,
    input logic           tx_line,
    input logic           tx_busy
);
    assert_halted_baud_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cd == '0) |-> !baud_tick);

    assert_idle_line_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> tx_line);

    assert_rx_clear_by_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_dreq) |-> $past(rd_en && addr == AW'(A_RXD)));

    assert_sticky_errors_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ovr) || $fell(fer) || $fell(per)) |-> $past(wr_en && addr == AW'(A_CMD) && wr_bit0));

    assert_local_pin_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2) |-> txd_pin);

    assert_remote_wire_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3) |-> (txd_pin == rxd_pin));
endmodule

bind sp_uart sp_uart_chk #(.CDW(CDW), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .txd_pin  (txd_pin),
    .rxd_pin  (rxd_pin),
    .rx_dreq  (rx_dreq),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .addr     (addr),
    .wr_bit0  (wr_data[0]),
    .ovr      (ovr),
    .fer      (fer),
    .per      (per),
    .cd       (cd),
    .baud_tick(baud_tick),
    .tx_line  (tx_line),
    .tx_busy  (tx_busy)
);

// File: tb/sp_uart_tb_top.sv
module sp_uart_tb_top;
    localparam int CDV = 2;
    localparam int BIT = 16 * CDV;
    localparam logic [2:0] CFG = 0, DIV = 1, TXD = 2, RXD = 3, STAT = 4, CMD = 5;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0, rxd_pin = 1'b1;
    logic [2:0]  addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        txd_pin, rx_dreq, tx_dreq;

    int tests = 0, fails = 0;
    bit finished = 1'b0;
    bit mon_follow = 1'b0, mon_high = 1'b0;
    int follow_bad = 0, high_bad = 0;

    always #5 clk = ~clk;

    sp_uart dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .rxd_pin(rxd_pin), .txd_pin(txd_pin),
        .rx_dreq(rx_dreq), .tx_dreq(tx_dreq)
    );

    always @(posedge clk) begin
        if (mon_follow && txd_pin !== rxd_pin) follow_bad++;
        if (mon_high && txd_pin !== 1'b1) high_bad++;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    function automatic logic bpar(input logic [7:0] d, input int sel);
        case (sel)
            0: return ^d;
            1: return ~^d;
            2: return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [10:0] frame_of(input logic [7:0] d, input int sel);
        return {1'b1, (sel < 4) ? bpar(d, sel) : 1'b1, d, 1'b0};
    endfunction

    task automatic send_rx(input logic [7:0] d, input int sel, input bit flip, input bit stop_v);
        rxd_pin = 1'b0; idle(BIT);
        for (int i = 0; i < 8; i++) begin rxd_pin = d[i]; idle(BIT); end
        if (sel < 4) begin rxd_pin = bpar(d, sel) ^ flip; idle(BIT); end
        rxd_pin = stop_v; idle(BIT);
        rxd_pin = 1'b1; idle(BIT);
    endtask

    task automatic capture(output logic [10:0] f);
        int n = 0;
        f = '1;
        while (txd_pin !== 1'b0 && n < 40 * BIT) begin @(negedge clk); n++; end
        idle(BIT / 2);
        f[0] = txd_pin;
        for (int i = 1; i < 11; i++) begin idle(BIT); f[i] = txd_pin; end
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset;
        logic [15:0] s;
        chk(txd_pin === 1'b1, "R2 idle line after reset", txd_pin, 1);
        rd(STAT, s);
        chk(s == 16'h0006, "R12 status after reset", s, 16'h0006);
        chk(rx_dreq === 1'b0, "R4 rx_dreq after reset", rx_dreq, 0);
        chk(tx_dreq === 1'b1, "R12 tx_dreq after reset", tx_dreq, 1);
    endtask

    task automatic t_halted;
        logic [15:0] s;
        logic [10:0] f;
        wr(CFG, 16'h0004);
        wr(TXD, 16'h003C);
        chk(tx_dreq === 1'b0, "R12 tx_dreq low while holding full", tx_dreq, 0);
        high_bad = 0; mon_high = 1'b1; idle(400); mon_high = 1'b0;
        chk(high_bad == 0, "R1 no frame with CD=0", high_bad, 0);
        rd(STAT, s);
        chk(s[1] == 1'b0, "R12 status bit1 while holding full", s[1], 0);
        wr(DIV, CDV);
        capture(f);
        chk(f == frame_of(8'h3C, 4), "R1 pending byte sent after CD set", f, frame_of(8'h3C, 4));
        idle(BIT);
    endtask

    task automatic t_bit_time;
        int len = 0, n = 0;
        wr(TXD, 16'h00A5);
        while (txd_pin !== 1'b0 && n < 4 * BIT) begin @(negedge clk); n++; end
        while (txd_pin === 1'b0 && len < 4 * BIT) begin @(negedge clk); len++; end
        chk(len == BIT, "R1 start bit length 16xCD", len, BIT);
        idle(11 * BIT);
    endtask

    task automatic t_tx(input logic [7:0] d, input int sel);
        logic [10:0] f;
        logic [15:0] s;
        wr(CFG, 16'(sel));
        wr(TXD, {8'h00, d});
        capture(f);
        chk(f == frame_of(d, sel), "R2 R3 transmitted frame", f, frame_of(d, sel));
        idle(BIT);
        rd(STAT, s);
        chk(s == 16'h0006, "R12 status after frame", s, 16'h0006);
    endtask

    task automatic t_rx_good;
        logic [15:0] s;
        wr(CFG, 16'h0004);
        send_rx(8'h96, 4, 1'b0, 1'b1);
        chk(rx_dreq === 1'b1, "R4 rx_dreq on receive", rx_dreq, 1);
        rd(STAT, s);
        chk(s == 16'h0007, "R4 status after receive", s, 16'h0007);
        rd(RXD, s);
        chk(s[7:0] == 8'h96, "R4 received byte", s[7:0], 8'h96);
        rd(STAT, s);
        chk(s == 16'h0006, "R4 status after read", s, 16'h0006);
        chk(rx_dreq === 1'b0, "R4 rx_dreq after read", rx_dreq, 0);
        for (int sel = 0; sel < 4; sel++) begin
            wr(CFG, 16'(sel));
            send_rx(8'h5D + 8'(sel), sel, 1'b0, 1'b1);
            rd(STAT, s);
            chk(s[5:3] == 3'b000, "R3 no error with matching parity", s[5:3], 0);
            rd(RXD, s);
            chk(s[7:0] == 8'h5D + 8'(sel), "R3 byte with parity", s[7:0], 8'h5D + sel);
        end
    endtask

    task automatic t_parity_err;
        logic [15:0] s;
        wr(CFG, 16'h0000);
        send_rx(8'h42, 0, 1'b1, 1'b1);
        rd(STAT, s);
        chk(s[5] == 1'b1, "R5 parity error flag", s[5], 1);
        rd(RXD, s);
        send_rx(8'h43, 0, 1'b0, 1'b1);
        rd(STAT, s);
        chk(s[5] == 1'b1, "R8 parity flag kept after good frame", s[5], 1);
        rd(RXD, s);
        chk(s[7:0] == 8'h43, "R8 good byte while flag set", s[7:0], 8'h43);
        wr(CMD, 16'h0001);
        rd(STAT, s);
        chk(s == 16'h0006, "R8 flags cleared by command", s, 16'h0006);
    endtask

    task automatic t_frame_err;
        logic [15:0] s;
        wr(CFG, 16'h0004);
        send_rx(8'h18, 4, 1'b0, 1'b0);
        idle(2 * BIT);
        rd(STAT, s);
        chk(s[4] == 1'b1, "R6 framing error flag", s[4], 1);
        rd(RXD, s);
        idle(12 * BIT);
        rd(RXD, s);
        wr(CMD, 16'h0001);
        rd(STAT, s);
        chk(s == 16'h0006, "R8 framing flag cleared", s, 16'h0006);
    endtask

    task automatic t_overrun;
        logic [15:0] s;
        send_rx(8'h11, 4, 1'b0, 1'b1);
        send_rx(8'h22, 4, 1'b0, 1'b1);
        rd(STAT, s);
        chk(s[3] == 1'b1, "R7 overrun flag", s[3], 1);
        rd(RXD, s);
        chk(s[7:0] == 8'h22, "R7 newer byte kept", s[7:0], 8'h22);
        wr(CMD, 16'h0001);
    endtask

    task automatic t_false_start;
        logic [15:0] s;
        rxd_pin = 1'b0; idle(6); rxd_pin = 1'b1;
        idle(3 * BIT);
        rd(STAT, s);
        chk(s[0] == 1'b0, "R13 short pulse rejected", s[0], 0);
        send_rx(8'h6C, 4, 1'b0, 1'b1);
        rd(RXD, s);
        chk(s[7:0] == 8'h6C, "R13 next frame received", s[7:0], 8'h6C);
    endtask

    task automatic t_echo;
        logic [15:0] s;
        wr(CFG, 16'h0014);
        wr(TXD, 16'h00F0);
        follow_bad = 0; mon_follow = 1'b1;
        send_rx(8'hC3, 4, 1'b0, 1'b1);
        mon_follow = 1'b0;
        chk(follow_bad == 0, "R9 echo pin follows rx", follow_bad, 0);
        rd(RXD, s);
        chk(s[7:0] == 8'hC3, "R9 receiver active in echo", s[7:0], 8'hC3);
        idle(12 * BIT);
    endtask

    task automatic t_local;
        logic [15:0] s;
        wr(CFG, 16'h0024);
        rxd_pin = 1'b0;
        high_bad = 0; mon_high = 1'b1;
        wr(TXD, 16'h005A);
        idle(12 * BIT);
        mon_high = 1'b0;
        chk(high_bad == 0, "R10 pin held high in local loop", high_bad, 0);
        rd(STAT, s);
        chk(s[5:0] == 6'h07, "R10 loop frame received cleanly", s[5:0], 6'h07);
        rd(RXD, s);
        chk(s[7:0] == 8'h5A, "R10 looped byte", s[7:0], 8'h5A);
        rxd_pin = 1'b1; idle(4);
    endtask

    task automatic t_remote;
        logic [15:0] s;
        wr(CFG, 16'h0034);
        follow_bad = 0;
        wr(TXD, 16'h0077);
        mon_follow = 1'b1;
        send_rx(8'h33, 4, 1'b0, 1'b1);
        mon_follow = 1'b0;
        idle(4 * BIT);
        chk(follow_bad == 0, "R11 pin wired to rx", follow_bad, 0);
        rd(STAT, s);
        chk(s[0] == 1'b0, "R11 receiver disconnected", s[0], 0);
        wr(CFG, 16'h0004);
    endtask

    initial begin
        idle(5);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_halted();
        t_bit_time();
        t_tx(8'hA5, 0);
        t_tx(8'h3B, 1);
        t_tx(8'h80, 2);
        t_tx(8'h01, 3);
        t_tx(8'hE7, 4);
        t_rx_good();
        t_parity_err();
        t_frame_err();
        t_overrun();
        t_false_start();
        t_echo();
        t_local();
        t_remote();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule